// File: doc/BRIEF.md
# Low-Frequency Carrier Burst Detector

This block decides whether a slow on-off-keyed carrier, near 40 kHz and already reduced to one digital bit by an analog front end, is really present. The raw bit is synchronized to a local timing clock. A symmetric hold-time filter then deglitches it, and the time between successive rising edges of the clean signal is measured. Each period that falls inside an acceptance window counts toward a group of thirteen. At the end of each group, the summed length of its thirteen periods is checked against a group window.

Two valid groups in a row, 26 accepted periods, produce a single detect pulse that lasts 2.5 us. A group whose total length falls outside the group window raises a one-clock error flag and sends the block back to waiting for a first group. Any period outside the acceptance window clears the count at once, so a new group must start from a clean edge.

All timing limits are derived from a clock-frequency parameter. Both outputs are plain strobes: they carry no payload and there is no back-pressure. A listener that needs them later must capture them itself.

Top module: `carrier_burst_detector`

## Requirements
- R1: The raw input passes through a two-stage synchronizer and then a symmetric filter. The filtered level changes only after the synchronized input has held the new value for HOLD consecutive clocks (7.5 us), so any shorter pulse or glitch is ignored.
- R2: The period is the number of clocks between consecutive rising edges of the filtered level. It is accepted when it lies between CLK_HZ/50000 and CLK_HZ/35000 clocks inclusive, which covers carriers from 35 kHz to 50 kHz.
- R3: A period outside the acceptance window clears the cycle count, the summed group length and the group stage. The first rising edge after an idle gap longer than the upper period limit counts as such a period.
- R4: Thirteen accepted periods in a row close a group. The group is valid when the sum of its thirteen periods lies between 265 us and 365 us inclusive, expressed in clocks.
- R5: A group whose sum falls outside the group window produces an error_flag pulse exactly one clock wide. It produces no detect, and the next group starts again as a first group.
- R6: A valid group that follows a valid first group produces one detect pulse exactly TICK clocks (2.5 us) wide. The stage then returns to first, so 52 accepted nominal periods give two detects.
- R7: A 100 kHz carrier (phases shorter than the hold time) and a 5 kHz carrier (period far above the window) produce neither detect nor error_flag.
- R8: While reset is asserted and directly after it, detect and error_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timing clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| carrier_raw | input | 1 | Asynchronous digitized carrier bit from the front end |
| detect | output | 1 | High for TICK clocks after two valid groups |
| error_flag | output | 1 | One-clock pulse when a group length is out of window |

## Verification
The bench builds the block with CLK_HZ set to 800 kHz. This gives a hold time of 6 clocks, a period window of 16 to 22 clocks, a group window of 212 to 292 clocks and a 2-clock detect pulse, so that every burst takes a few hundred clocks. At this rate the group-window lower edge can be reached exactly: twelve 16-clock periods plus one of 20 clocks sum to 212 and pass, while one of 19 clocks gives 211 and fails. A TICK of two clocks also makes the stretched pulse width observable. Glitches shorter than six clocks can be placed inside a high phase, and a 100 kHz carrier has phases of four clocks, below the filter hold.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic {
    ST_FIRST  = 1'b0,
    ST_SECOND = 1'b1
  } grp_stage_e;

  // Number of clock cycles spanning a duration in nanoseconds.
  function automatic int clocks_for_ns(input longint hz, input longint ns);
    return int'((hz * ns) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/cbd_deglitch.sv
module cbd_deglitch #(
  parameter int STAGES = 2,
  parameter int HOLD   = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  localparam int HW = $clog2(HOLD + 1);

  logic [STAGES-1:0] sync_q;
  logic              din_s;
  logic [HW-1:0]     run_cnt;
  logic              filt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-2:0], din};
  end
  assign din_s = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q  <= 1'b0;
      run_cnt <= '0;
    end else if (din_s == filt_q) begin
      run_cnt <= '0;
    end else if (run_cnt == HW'(HOLD - 1)) begin
      filt_q  <= din_s;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign level = filt_q;

  // R1: a change of the filtered level always moves toward the sampled input
  p_flip_follows_input_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> (filt_q == $past(din_s)));

  // R1: the hold counter never passes the hold limit
  p_hold_bound_r1: assert property (@(posedge clk) disable iff (rst)
    run_cnt < HW'(HOLD));

endmodule

// File: rtl/cbd_period_meter.sv
module cbd_period_meter #(
  parameter int PMIN = 40,
  parameter int PMAX = 57,
  parameter int PW   = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          level,
  output logic          qual,
  output logic          bad,
  output logic [PW-1:0] period
);
  localparam int PSAT = PMAX + 1;

  logic          level_q;
  logic          rise;
  logic [PW-1:0] pcnt;
  logic          in_win;

  assign rise   = level & ~level_q;
  assign in_win = (pcnt >= PW'(PMIN)) && (pcnt <= PW'(PMAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      pcnt    <= PW'(PSAT);
      qual    <= 1'b0;
      bad     <= 1'b0;
      period  <= '0;
    end else begin
      level_q <= level;
      qual    <= rise & in_win;
      bad     <= rise & ~in_win;
      if (rise) begin
        period <= pcnt;
        pcnt   <= PW'(1);
      end else if (pcnt != PW'(PSAT)) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  // R2: a period is either accepted or rejected, never both
  p_qual_bad_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({qual, bad}));

  // R3: the period counter stays in its saturating range
  p_pcnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    (pcnt != '0) && (pcnt <= PW'(PSAT)));

  // R2: a strobe only follows a rising edge of the filtered level
  p_strobe_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (qual || bad) |-> $past(level) && !$past(level_q));

endmodule

// File: rtl/cbd_group_checker.sv
module cbd_group_checker
  import cbd_pkg::*;
#(
  parameter int GROUP_LEN = 13,
  parameter int GMIN      = 530,
  parameter int GMAX      = 730,
  parameter int PW        = 7,
  parameter int PMAX      = 57
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          qual,
  input  logic          bad,
  input  logic [PW-1:0] period,
  output logic          hit,
  output logic          err
);
  localparam int CW = $clog2(GROUP_LEN + 1);
  localparam int GW = $clog2(GROUP_LEN * (PMAX + 1) + 1) + 1;

  logic [CW-1:0] cnt;
  logic [GW-1:0] sum;
  logic [GW-1:0] total;
  logic          total_ok;
  grp_stage_e    stage;

  always_comb begin
    total    = sum + GW'(period);
    total_ok = (total >= GW'(GMIN)) && (total <= GW'(GMAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sum   <= '0;
      stage <= ST_FIRST;
      hit   <= 1'b0;
      err   <= 1'b0;
    end else begin
      hit <= 1'b0;
      err <= 1'b0;
      if (bad) begin
        cnt   <= '0;
        sum   <= '0;
        stage <= ST_FIRST;
      end else if (qual) begin
        if (cnt == CW'(GROUP_LEN - 1)) begin
          cnt <= '0;
          sum <= '0;
          if (total_ok) begin
            if (stage == ST_FIRST) begin
              stage <= ST_SECOND;
            end else begin
              hit   <= 1'b1;
              stage <= ST_FIRST;
            end
          end else begin
            err   <= 1'b1;
            stage <= ST_FIRST;
          end
        end else begin
          cnt <= cnt + 1'b1;
          sum <= total;
        end
      end
    end
  end

  // R4: the cycle count never reaches the group length
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(GROUP_LEN));

  // R5: a group ends either valid or in error, never both
  p_hit_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit, err}));

  // R5: error is a single-clock pulse
  p_err_single_r5: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R6: a detect closes the second group and returns to the first stage
  p_hit_from_second_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (stage == ST_FIRST) && ($past(stage) == ST_SECOND));

  // R3: an out-of-window period leaves a cleared group
  p_bad_clears_r3: assert property (@(posedge clk) disable iff (rst)
    $past(bad) |-> (cnt == '0) && (sum == '0) && (stage == ST_FIRST));

endmodule

// File: rtl/cbd_pulse_stretch.sv
module cbd_pulse_stretch #(
  parameter int TICK = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  generate
    if (TICK == 1) begin : g_direct
      logic out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= trig;
      end
      assign pulse = out_q;
    end else begin : g_count
      localparam int TW = $clog2(TICK + 1);
      logic [TW-1:0] left;
      always_ff @(posedge clk) begin
        if (rst)                left <= '0;
        else if (trig)          left <= TW'(TICK);
        else if (left != '0)    left <= left - 1'b1;
      end
      assign pulse = (left != '0);

      // R6: a stretched pulse does not end after its first clock
      p_width_min_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |=> pulse);
    end
  endgenerate
endmodule

// File: rtl/carrier_burst_detector.sv
module carrier_burst_detector
  import cbd_pkg::*;
#(
  parameter int CLK_HZ      = 2_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int GROUP_LEN   = 13,
  parameter int FLO_HZ      = 35_000,
  parameter int FHI_HZ      = 50_000,
  parameter int HOLD_NS     = 7_500,
  parameter int GLO_NS      = 265_000,
  parameter int GHI_NS      = 365_000,
  parameter int PULSE_NS    = 2_500
) (
  input  logic clk,
  input  logic rst,
  input  logic carrier_raw,
  output logic detect,
  output logic error_flag
);
  localparam int TICK = clocks_for_ns(CLK_HZ, PULSE_NS);
  localparam int HOLD = clocks_for_ns(CLK_HZ, HOLD_NS);
  localparam int PMIN = CLK_HZ / FHI_HZ;
  localparam int PMAX = CLK_HZ / FLO_HZ;
  localparam int GMIN = clocks_for_ns(CLK_HZ, GLO_NS);
  localparam int GMAX = clocks_for_ns(CLK_HZ, GHI_NS);
  localparam int PW   = $clog2(PMAX + 2);

  logic          level;
  logic          qual;
  logic          bad;
  logic [PW-1:0] period;
  logic          hit;

  cbd_deglitch #(.STAGES(SYNC_STAGES), .HOLD(HOLD)) u_deglitch (
    .clk(clk), .rst(rst), .din(carrier_raw), .level(level)
  );

  cbd_period_meter #(.PMIN(PMIN), .PMAX(PMAX), .PW(PW)) u_meter (
    .clk(clk), .rst(rst), .level(level),
    .qual(qual), .bad(bad), .period(period)
  );

  cbd_group_checker #(
    .GROUP_LEN(GROUP_LEN), .GMIN(GMIN), .GMAX(GMAX), .PW(PW), .PMAX(PMAX)
  ) u_group (
    .clk(clk), .rst(rst), .qual(qual), .bad(bad), .period(period),
    .hit(hit), .err(error_flag)
  );

  cbd_pulse_stretch #(.TICK(TICK)) u_stretch (
    .clk(clk), .rst(rst), .trig(hit), .pulse(detect)
  );

  // R8: outputs are quiet in the first clock after reset
  p_quiet_after_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> !detect && !error_flag);

endmodule

// File: tb/carrier_burst_detector_test.sv
module carrier_burst_detector_test;
  localparam int CLK_HZ = 800_000;
  localparam int TICK   = CLK_HZ / 400_000;
  localparam int HOLD   = CLK_HZ * 3 / 400_000;
  localparam int PMIN   = CLK_HZ / 50_000;
  localparam int PMAX   = CLK_HZ / 35_000;
  localparam int GMIN   = CLK_HZ / 1000 * 265 / 1000;
  localparam int GMAX   = CLK_HZ / 1000 * 365 / 1000;
  localparam int GL     = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carrier_raw = 1'b0;
  logic detect;
  logic error_flag;

  always #2 clk = ~clk;

  carrier_burst_detector #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .carrier_raw(carrier_raw),
    .detect(detect), .error_flag(error_flag)
  );

  int checks = 0;
  int fails  = 0;
  int det_seen = 0;
  int err_seen = 0;
  int det_run  = 0;
  bit done = 1'b0;
  int hi_buf [0:127];
  int lo_buf [0:127];
  int gl_buf [0:127];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (error_flag) err_seen++;
      if (detect) begin
        if (det_run == 0) det_seen++;
        det_run++;
      end else if (det_run != 0) begin
        check("R6 detect width", det_run, TICK);
        det_run = 0;
      end
    end
  end

  // Period-level model of the requirements
  function automatic void model(input int np, output int edet, output int eerr);
    int c = 0;
    int s = 0;
    bit second = 1'b0;
    edet = 0;
    eerr = 0;
    for (int i = 0; i < np; i++) begin
      int p = hi_buf[i] + lo_buf[i];
      if (p < PMIN || p > PMAX) begin
        c = 0; s = 0; second = 1'b0;
      end else if (c == GL - 1) begin
        int t = s + p;
        if (t >= GMIN && t <= GMAX) begin
          if (second) begin edet++; second = 1'b0; end
          else second = 1'b1;
        end else begin
          eerr++; second = 1'b0;
        end
        c = 0; s = 0;
      end else begin
        c++; s += p;
      end
    end
  endfunction

  task automatic play(input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      if (gl_buf[i] != 0) begin
        carrier_raw = 1'b1; repeat (gl_buf[i]) @(negedge clk);
        carrier_raw = 1'b0; repeat (2) @(negedge clk);
        carrier_raw = 1'b1; repeat (hi_buf[i] - gl_buf[i] - 2) @(negedge clk);
      end else begin
        carrier_raw = 1'b1; repeat (hi_buf[i]) @(negedge clk);
      end
      carrier_raw = 1'b0; repeat (lo_buf[i]) @(negedge clk);
    end
    repeat (80) @(negedge clk);
  endtask

  task automatic burst(input string req, input int ncyc, input bit use_model,
                       input int xdet, input int xerr);
    int d0 = det_seen;
    int e0 = err_seen;
    int edet = xdet;
    int eerr = xerr;
    if (use_model) model(ncyc - 1, edet, eerr);
    play(ncyc);
    check({req, " detect count"}, det_seen - d0, edet);
    check({req, " error count"}, err_seen - e0, eerr);
  endtask

  task automatic fill(input int ncyc, input int hi, input int lo);
    for (int i = 0; i < ncyc; i++) begin
      hi_buf[i] = hi; lo_buf[i] = lo; gl_buf[i] = 0;
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check("R8 detect in reset", int'(detect), 0);
    check("R8 error in reset", int'(error_flag), 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check("R8 detect after reset", int'(detect), 0);
    check("R8 error after reset", int'(error_flag), 0);

    // R6: nominal 25 us carrier, 26 accepted periods
    fill(27, 10, 10);
    burst("R6 nominal", 27, 1'b0, 1, 0);
    // R6: 52 periods give two detects
    fill(53, 10, 10);
    burst("R6 double", 53, 1'b0, 2, 0);
    // R4: only one group of 13, no detect
    fill(14, 10, 10);
    burst("R4 single group", 14, 1'b0, 0, 0);
    // R5: 13 x 16 = 208 below group window
    fill(27, 8, 8);
    burst("R5 short groups", 27, 1'b0, 0, 2);
    // R4: boundary sum 12x16 + 20 = 212 accepted
    fill(27, 8, 8);
    lo_buf[12] = 12; lo_buf[25] = 12;
    burst("R4 group edge 212", 27, 1'b0, 1, 0);
    // R5: boundary sum 12x16 + 19 = 211 rejected
    fill(27, 8, 8);
    lo_buf[12] = 11; lo_buf[25] = 11;
    burst("R5 group edge 211", 27, 1'b0, 0, 2);
    // R2: periods 16 and 22 at window edges, 13x22=286 in group window
    fill(27, 11, 11);
    burst("R2 upper period edge", 27, 1'b0, 1, 0);
    // R3: a 23-clock period mid-burst clears the count
    fill(30, 10, 10);
    lo_buf[10] = 13;
    burst("R3 out of window reset", 30, 1'b1, 1, 0);
    fill(30, 10, 10);
    lo_buf[5] = 5; hi_buf[5] = 10; lo_buf[6] = 10;
    hi_buf[5] = 7; lo_buf[5] = 8;
    burst("R3 short period reset", 30, 1'b1, 0, 0);
    // R7: 100 kHz and 5 kHz carriers
    fill(100, 4, 4);
    burst("R7 100kHz", 100, 1'b0, 0, 0);
    fill(30, 80, 80);
    burst("R7 5kHz", 30, 1'b0, 0, 0);
    // R1: short glitches inside the high phase are ignored
    fill(27, 12, 8);
    for (int i = 0; i < 27; i++) gl_buf[i] = 7;
    burst("R1 glitch filtered", 27, 1'b0, 1, 0);

    // Constrained random bursts
    for (int b = 0; b < 36; b++) begin
      int mode = $urandom_range(0, 2);
      int ncyc = $urandom_range(20, 60);
      for (int i = 0; i < ncyc; i++) begin
        int p;
        if (mode == 0)      p = $urandom_range(18, 22);
        else if (mode == 1) p = $urandom_range(16, 18);
        else                p = $urandom_range(14, 25);
        hi_buf[i] = $urandom_range(6, p - 6);
        lo_buf[i] = p - hi_buf[i];
        gl_buf[i] = 0;
      end
      burst("R4 R5 R6 random", ncyc, 1'b1, 0, 0);
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule